// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block supervises a processor. It owns the processor's active-low reset, which stays low while an external comparator reports a bad supply. Once the supply is good, the reset is held low for a fixed power-up delay before it is released. After release, the processor must send trigger edges inside an allowed time window.

A trigger that comes too soon after the previous one is a fault. A window that runs out with no trigger is also a fault. Either fault pulls the reset low for the full delay. The window right after any release has no lower limit, so the processor may trigger it at any time.

All timing comes from one prescaler. The prescaler turns the clock into base ticks of `BASE_US` microseconds. Every limit is a whole number of these ticks. Two strap inputs set the window: one selects the upper limit and the other selects the ratio for the lower limit. The straps are captured each time the reset is released. A two-bit status output reports what caused the most recent watchdog reset.

Top module: `wdog_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0, `rst_no` is 0 from the next clock edge on, and `fault_o` reads 0 (no fault).
- R2: After `supply_ok_i` goes to 1, `rst_no` stays 0 for exactly `DELAY_TICKS` x `TICK_DIV` cycles and then goes to 1. Here `TICK_DIV` = `CLK_HZ`/1e6 x `BASE_US`.
- R3: If `supply_ok_i` drops while `rst_no` is 1, `rst_no` goes to 0 at the next edge, without waiting for the delay.
- R4: A trigger is a 0-to-1 transition of `trig_i`, passed through a two-flop synchronizer. The block acts on it at the third clock edge after the input rises. A level held high counts only once.
- R5: The upper window limit U in ticks depends on `tsel_i`: 0 gives `SHORT_TICKS`, 1 gives `LONG_TICKS`, and 2 or 3 gives `prog_i`+1.
- R6: In the first window after any release, every trigger before the upper limit is accepted.
- R7: In every later window, a trigger is early when E x K < U. E is the number of whole ticks since the window started. K is 32 when `ratio_i`=0 and 128 when `ratio_i`=1. An early trigger drops `rst_no` for the full delay and sets `fault_o` to 1.
- R8: If E reaches U with no trigger, `rst_no` drops for the full delay and `fault_o` becomes 2. After release, the first window has no lower limit again.
- R9: An accepted trigger restarts the window count from zero and makes the next window bounded.
- R10: Trigger edges that arrive while `rst_no` is 0 have no effect on the timing or on `fault_o`.
- R11: `tsel_i`, `prog_i` and `ratio_i` are captured when `rst_no` rises. Changes to them while running have no effect until the next release.
- R12: `fault_o` keeps its value through the delay and the windows that follow, until the next fault or until the supply is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| supply_ok_i | input | 1 | Synchronous supply-good flag from an external comparator |
| trig_i | input | 1 | Watchdog trigger from the processor (asynchronous) |
| tsel_i | input | 2 | Upper-limit select strap |
| prog_i | input | PROG_W | Programmable upper limit, minus one, in ticks |
| ratio_i | input | 1 | Window-ratio select strap |
| rst_no | output | 1 | Active-low processor reset |
| fault_o | output | 2 | Last fault cause: 0 none, 1 early trigger, 2 timeout |

## Verification
Most internal faults show up at `rst_no` within one clock. Examples are a window count that is off by one, a bounded flag set at the wrong time, or a strap captured at the wrong moment. Each of these moves a timeout edge, or turns an accepted trigger into an early-trigger reset, or the reverse.

Delay-counter and prescaler errors show up when the reset is released: the edge arrives early or late by a tick or by a single cycle. A wrong fault code stays visible on `fault_o` for the whole delay that follows. For these reasons the outputs are compared against a cycle-level model on every clock. Together, the stimulus reaches every lower-limit boundary and every upper-limit mode.

// File: rtl/wdog_sup_pkg.sv
package wdog_sup_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_EARLY   = 2'd1,
    FLT_TIMEOUT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } state_e;

  // lower bound: elapsed << shift compared against upper limit
  localparam int unsigned RATIO_SH_LO = 5;
  localparam int unsigned RATIO_SH_HI = 7;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < DIV);
endmodule

// File: rtl/wdog_trig_edge.sv
module wdog_trig_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_sup_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 40,
  parameter int unsigned LONG_TICKS  = 400,
  parameter int unsigned PROG_W      = 6,
  parameter int unsigned UP_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [1:0]        tsel_i,
  input  logic [PROG_W-1:0] prog_i,
  input  logic              ratio_i,
  output logic              early_o,
  output logic              expire_o
);
  localparam int unsigned EW = UP_W + RATIO_SH_HI;

  logic [UP_W-1:0] upper_d, upper_q, elapsed_q;
  logic            ratio_q;
  logic [EW-1:0]   scaled;

  always_comb begin
    unique case (tsel_i)
      2'd0:    upper_d = UP_W'(SHORT_TICKS);
      2'd1:    upper_d = UP_W'(LONG_TICKS);
      default: upper_d = UP_W'(prog_i) + 1'b1;
    endcase
  end

  assign expire_o = run_i && tick_i && (elapsed_q == upper_q - 1'b1);
  assign scaled   = ratio_q ? (EW'(elapsed_q) << RATIO_SH_HI)
                            : (EW'(elapsed_q) << RATIO_SH_LO);
  assign early_o  = scaled < EW'(upper_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q   <= UP_W'(SHORT_TICKS);
      ratio_q   <= 1'b0;
      elapsed_q <= '0;
    end else if (arm_i) begin
      upper_q   <= upper_d;
      ratio_q   <= ratio_i;
      elapsed_q <= '0;
    end else if (restart_i) begin
      elapsed_q <= '0;
    end else if (run_i && tick_i && !expire_o) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  // R8
  elapsed_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elapsed_q < upper_q);

  // R11
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> $stable(upper_q) && $stable(ratio_q));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BASE_US     = 6250,
  parameter int unsigned DELAY_TICKS = 4,
  parameter int unsigned SHORT_TICKS = 40,
  parameter int unsigned LONG_TICKS  = 400,
  parameter int unsigned PROG_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              trig_i,
  input  logic [1:0]        tsel_i,
  input  logic [PROG_W-1:0] prog_i,
  input  logic              ratio_i,
  output logic              rst_no,
  output logic [1:0]        fault_o
);
  localparam int unsigned TICK_DIV = (CLK_HZ / 1_000_000) * BASE_US;
  localparam int unsigned MAX_UP   = (LONG_TICKS > (1 << PROG_W)) ? LONG_TICKS : (1 << PROG_W);
  localparam int unsigned UP_W     = $clog2(MAX_UP + 1);
  localparam int unsigned DW       = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [DW-1:0] D_LAST = DW'(DELAY_TICKS - 1);

  state_e        state_q, state_d;
  fault_e        fault_q, fault_d;
  logic [DW-1:0] dcnt_q;
  logic          bounded_q;
  logic          tick, trig_edge, early, expire;
  logic          arm, restart, pre_clr;

  wdog_trig_edge #(.STAGES(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  wdog_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr),
    .tick_o (tick)
  );

  wdog_window #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .PROG_W      (PROG_W),
    .UP_W        (UP_W)
  ) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .restart_i (restart),
    .run_i     (state_q == ST_RUN),
    .tick_i    (tick),
    .tsel_i    (tsel_i),
    .prog_i    (prog_i),
    .ratio_i   (ratio_i),
    .early_o   (early),
    .expire_o  (expire)
  );

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    arm     = 1'b0;
    restart = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        fault_d = FLT_NONE;
        if (supply_ok_i) state_d = ST_DELAY;
      end
      ST_DELAY: begin
        if (!supply_ok_i) begin
          state_d = ST_HOLD;
          fault_d = FLT_NONE;
        end else if (tick && dcnt_q == D_LAST) begin
          state_d = ST_RUN;
          arm     = 1'b1;
        end
      end
      ST_RUN: begin
        if (!supply_ok_i) begin
          state_d = ST_HOLD;
          fault_d = FLT_NONE;
        end else if (trig_edge) begin
          if (bounded_q && early) begin
            state_d = ST_DELAY;
            fault_d = FLT_EARLY;
          end else begin
            restart = 1'b1;
          end
        end else if (expire) begin
          state_d = ST_DELAY;
          fault_d = FLT_TIMEOUT;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  assign pre_clr = (state_d != state_q) || restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HOLD;
      fault_q   <= FLT_NONE;
      dcnt_q    <= '0;
      bounded_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      if (state_d != state_q)                 dcnt_q <= '0;
      else if (state_q == ST_DELAY && tick)   dcnt_q <= dcnt_q + 1'b1;
      if (arm)          bounded_q <= 1'b0;
      else if (restart) bounded_q <= 1'b1;
    end
  end

  assign rst_no  = (state_q == ST_RUN);
  assign fault_o = fault_q;

  // R1
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !rst_no && fault_o == FLT_NONE);

  // R2
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(dcnt_q) == D_LAST && $past(tick));

  // R6
  first_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && supply_ok_i && trig_edge && !bounded_q) |=> rst_no);

  // R8
  expire_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && supply_ok_i && !trig_edge && expire)
      |=> !rst_no && fault_o == FLT_TIMEOUT);

  // R10
  ignore_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |=> $stable(fault_o) || fault_o == FLT_NONE);
endmodule

// File: tb/wdog_supervisor_tb_top.sv
module wdog_supervisor_tb_top;
  localparam int unsigned DIV   = 8;
  localparam int unsigned DLY   = 4;
  localparam int unsigned SHORT = 40;
  localparam int unsigned LONG  = 400;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       trig_i = 1'b0;
  logic [1:0] tsel_i = 2'd0;
  logic [5:0] prog_i = 6'd0;
  logic       ratio_i = 1'b0;
  logic       rst_no;
  logic [1:0] fault_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wdog_supervisor #(
    .CLK_HZ(1_000_000), .BASE_US(DIV), .DELAY_TICKS(DLY),
    .SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .PROG_W(6)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .trig_i(trig_i),
    .tsel_i(tsel_i), .prog_i(prog_i), .ratio_i(ratio_i),
    .rst_no(rst_no), .fault_o(fault_o)
  );

  // behavioural reference: 0 hold, 1 delay, 2 run
  int m_mode = 0, m_dcyc = 0, m_wcyc = 0, m_up = SHORT, m_k = 32, m_flt = 0;
  bit m_bnd = 1'b0;
  bit hist[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk_i) begin
    bit e;
    if (!rst_ni) begin
      m_mode = 0; m_flt = 0; m_bnd = 0; m_dcyc = 0; m_wcyc = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      e = hist[1] && !hist[2];
      case (m_mode)
        0: begin
          m_flt = 0;
          if (supply_ok_i) begin m_mode = 1; m_dcyc = 0; end
        end
        1: begin
          if (!supply_ok_i) begin m_mode = 0; m_flt = 0; end
          else begin
            m_dcyc++;
            if (m_dcyc == DLY * DIV) begin
              m_mode = 2; m_wcyc = 0; m_bnd = 0;
              m_up = (tsel_i == 0) ? SHORT : (tsel_i == 1) ? LONG : int'(prog_i) + 1;
              m_k  = ratio_i ? 128 : 32;
            end
          end
        end
        default: begin
          if (!supply_ok_i) begin m_mode = 0; m_flt = 0; end
          else if (e) begin
            if (m_bnd && (m_wcyc / DIV) * m_k < m_up) begin
              m_mode = 1; m_dcyc = 0; m_flt = 1;
            end else begin
              m_wcyc = 0; m_bnd = 1;
            end
          end else begin
            m_wcyc++;
            if (m_wcyc == m_up * DIV) begin m_mode = 1; m_dcyc = 0; m_flt = 2; end
          end
        end
      endcase
      hist.push_front(trig_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      checks++;
      if (rst_no !== (m_mode == 2) || fault_o !== 2'(m_flt)) begin
        failures++;
        $display("FAIL %s: rst_no=%0b fault=%0d expected rst_no=%0b fault=%0d at %0t",
                 cur_req, rst_no, fault_o, (m_mode == 2), m_flt, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse();
    trig_i = 1'b1; cyc(2); trig_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished (req %s)", cur_req);
    finish_run();
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    cyc(3);
    checks++;
    if (rst_no !== 1'b0 || fault_o !== 2'd0) begin
      failures++;
      $display("FAIL R1: rst_no=%0b fault=%0d expected 0/0", rst_no, fault_o);
    end
    rst_ni = 1'b1; cyc(10);
    // R10 triggers with supply low
    cur_req = "R10";
    pulse(); cyc(4); pulse(); cyc(10);
    // R2 power-up delay
    cur_req = "R2";
    supply_ok_i = 1'b1; cyc(40);
    // R6 unbounded first window
    cur_req = "R6";
    pulse(); cyc(5);
    // R7 early trigger, ratio 1:32
    cur_req = "R7";
    pulse(); cyc(60);
    // R9 accepted triggers restart window
    cur_req = "R9";
    cyc(10); pulse(); cyc(20); pulse(); cyc(30); pulse();
    // R8 timeout, short limit
    cur_req = "R8";
    cyc(400);
    // R12 fault code held
    cur_req = "R12";
    cyc(50);
    // R11 straps changed while running: ignored until release
    cur_req = "R11";
    tsel_i = 2'd1; ratio_i = 1'b1;
    cyc(400);
    // R7 ratio 1:128 boundaries
    cur_req = "R7";
    pulse(); cyc(4); pulse(); cyc(50);
    pulse(); cyc(28); pulse(); cyc(50);
    pulse(); cyc(36); pulse(); cyc(36);
    // R5 long limit, then programmable limit latched at next release
    cur_req = "R5";
    tsel_i = 2'd2; prog_i = 6'd9; ratio_i = 1'b0;
    cyc(3400);
    cyc(250);
    tsel_i = 2'd0;
    // R4 held level counts once
    cur_req = "R4";
    pulse(); cyc(10); trig_i = 1'b1; cyc(60); trig_i = 1'b0; cyc(60);
    // R10 triggers during watchdog reset
    cur_req = "R10";
    cyc(100); pulse(); cyc(6); pulse(); cyc(60);
    // R3 supply loss in run and in delay
    cur_req = "R3";
    supply_ok_i = 1'b0; cyc(5); supply_ok_i = 1'b1; cyc(20);
    supply_ok_i = 1'b0; cyc(3); supply_ok_i = 1'b1; cyc(40);
    pulse(); cyc(20);
    supply_ok_i = 1'b0; cyc(2);
    checks++;
    if (rst_no !== 1'b0) begin
      failures++;
      $display("FAIL R3: rst_no=%0b expected 0", rst_no);
    end
    cyc(5);
    finish_run();
  end
endmodule